// File: doc/BRIEF.md
# DMA Channel Sequencer

This block is the control core of a multi-channel DMA engine. Every channel keeps a live memory pointer and an item counter, plus a second pointer/counter pair that is held in reserve. A channel becomes a candidate for service when its peripheral raises a request, the channel is switched on and its live counter is nonzero. When the shared bus master is idle, the lowest-numbered candidate is chosen. Its address is put on a simple valid/done handshake toward the data path. When the data path completes the item, the channel's pointer moves forward by the item size and its counter drops by one.

When a live counter runs out and the reserve pair holds work, the reserve pair becomes live in the same step. Software can therefore queue the next buffer while the current one drains. A ring option keeps the reserve pair after the swap, so one buffer is replayed without end. Software reaches every channel through a flat write port and a combinational read port. Each channel also records the worst wait, in cycles, between a request and its grant. The worst-wait counter saturates at full scale.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, every pointer, counter, mode, mask and latency value reads 0. The status field of each channel reads 0x6. bus_valid and irq are low.
- R2: When no transfer is in flight, the lowest-numbered eligible channel is granted. A channel is eligible when req is high, the channel is enabled and its live counter is nonzero. From the next cycle, bus_valid is high, with bus_ch and bus_addr held until the cycle in which bus_done is sampled high.
- R3: Mode field (select 5), bits [1:0]: 0 means byte, 1 halfword, 2 or 3 word. After a good transfer the live pointer grows by 1, 2 or 4.
- R4: A good transfer decrements the live counter. If the counter was 1 and the reserve counter is nonzero, the reserve pointer and count become live instead. The reserve pair is then cleared.
- R5: With mode bit 2 (ring) set, the reserve pair keeps its values when it is copied into the live pair.
- R6: Writing the reserve count (select 3) while the live count is 0 loads the live count with the written value and the live pointer with the reserve pointer, in one cycle.
- R7: Status (select 6) bit0 = enabled; bit1 = reserve count is zero; bit2 = live and reserve counts both zero; bit3 = bus error seen.
- R8: bus_done with bus_err sets the error flag, switches the channel off and leaves its pointer and counter unchanged. Control (select 4) bit2 clears the error flag.
- R9: A write to mask-set (select 7) sets the mask bits given as ones. A write to mask-clear (select 8) clears them. Zero bits have no effect. Mask bits [2:0] map to the reserve-empty, complete and error flags. irq[ch] is the OR of the masked flags. Select 7 reads back the mask.
- R10: Select 9 reads the largest request-to-grant wait of the channel. The value saturates at 2^LW-1. A write to select 9 with bit0 set clears it.
- R11: Control bit0 switches a channel on and bit1 switches it off. When both bits are written together, bit1 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NCH | Peripheral request per channel |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | IW | Channel addressed by the write |
| wr_sel | input | 4 | Field select of the write |
| wr_data | input | DW | Write data |
| rd_ch | input | IW | Channel addressed by the read |
| rd_sel | input | 4 | Field select of the read |
| rd_data | output | DW | Read data (combinational) |
| bus_valid | output | 1 | Transfer in flight |
| bus_addr | output | AW | Memory address of the transfer |
| bus_ch | output | IW | Channel owning the transfer |
| bus_done | input | 1 | Data path finished the transfer |
| bus_err | input | 1 | Transfer failed (with bus_done) |
| irq | output | NCH | Per-channel interrupt |

## Verification
A grant appears on bus_valid one clock after the edge at which an eligible request is sampled. Pointer, counter, reserve, flag and worst-wait changes all take effect at the edge that samples bus_done, a grant or a write. Because the read port and irq are combinational, those changes are visible in the following low clock phase. The bench advances its reference model at each rising edge. It compares the bus outputs, irq and a read field that rotates across every channel and select 5 ns after each falling edge, so each result is sampled in the first cycle in which it is due. Directed reads with hand-computed values are placed right after the writes or transfer runs they depend on.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  // field selects of the register port
  localparam logic [3:0] SEL_ADDR  = 4'd0;
  localparam logic [3:0] SEL_CNT   = 4'd1;
  localparam logic [3:0] SEL_ARLD  = 4'd2;
  localparam logic [3:0] SEL_CRLD  = 4'd3;
  localparam logic [3:0] SEL_CTRL  = 4'd4;
  localparam logic [3:0] SEL_MODE  = 4'd5;
  localparam logic [3:0] SEL_STAT  = 4'd6;
  localparam logic [3:0] SEL_IESET = 4'd7;
  localparam logic [3:0] SEL_IECLR = 4'd8;
  localparam logic [3:0] SEL_LAT   = 4'd9;
endpackage

// File: rtl/dcs_chan.sv
module dcs_chan
  import dcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          xfer_done,
  input  logic          xfer_err,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] rld_addr,
  output logic [CW-1:0] cur_cnt,
  output logic [CW-1:0] rld_cnt,
  output logic [2:0]    mode,
  output logic          ch_en,
  output logic          err_flag,
  output logic [2:0]    imask
);
  logic [AW-1:0] step;
  logic [AW-1:0] n_addr, n_raddr;
  logic [CW-1:0] n_cnt, n_rcnt;
  logic [2:0]    n_mode, n_imask;
  logic          n_en, n_err;

  always_comb begin
    case (mode[1:0])
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  always_comb begin
    n_addr  = cur_addr;
    n_raddr = rld_addr;
    n_cnt   = cur_cnt;
    n_rcnt  = rld_cnt;
    n_mode  = mode;
    n_imask = imask;
    n_en    = ch_en;
    n_err   = err_flag;
    if (xfer_done) begin
      if (xfer_err) begin
        n_err = 1'b1;
        n_en  = 1'b0;
      end else if (cur_cnt == CW'(1) && rld_cnt != '0) begin
        n_addr = rld_addr;
        n_cnt  = rld_cnt;
        if (!mode[2]) begin
          n_raddr = '0;
          n_rcnt  = '0;
        end
      end else begin
        n_addr = cur_addr + step;
        n_cnt  = cur_cnt - CW'(1);
      end
    end
    if (wr_en) begin
      case (wr_sel)
        SEL_ADDR: n_addr  = wr_data[AW-1:0];
        SEL_CNT:  n_cnt   = wr_data[CW-1:0];
        SEL_ARLD: n_raddr = wr_data[AW-1:0];
        SEL_CRLD: begin
          if (n_cnt == '0) begin
            n_cnt  = wr_data[CW-1:0];
            n_addr = n_raddr;
            if (mode[2]) n_rcnt = wr_data[CW-1:0];
            else begin
              n_raddr = '0;
              n_rcnt  = '0;
            end
          end else begin
            n_rcnt = wr_data[CW-1:0];
          end
        end
        SEL_CTRL: begin
          if (wr_data[0]) n_en = 1'b1;
          if (wr_data[1]) n_en = 1'b0;
          if (wr_data[2]) n_err = 1'b0;
        end
        SEL_MODE:  n_mode  = wr_data[2:0];
        SEL_IESET: n_imask = imask | wr_data[2:0];
        SEL_IECLR: n_imask = imask & ~wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      rld_addr <= '0;
      cur_cnt  <= '0;
      rld_cnt  <= '0;
      mode     <= '0;
      imask    <= '0;
      ch_en    <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      cur_addr <= n_addr;
      rld_addr <= n_raddr;
      cur_cnt  <= n_cnt;
      rld_cnt  <= n_rcnt;
      mode     <= n_mode;
      imask    <= n_imask;
      ch_en    <= n_en;
      err_flag <= n_err;
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_err && !wr_en && cur_cnt > CW'(1))
      |=> (cur_cnt == $past(cur_cnt) - CW'(1)));

  // R5
  ring_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_err && !wr_en && mode[2])
      |=> (rld_cnt == $past(rld_cnt) && rld_addr == $past(rld_addr)));

  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && xfer_err && !wr_en)
      |=> (err_flag && !ch_en && cur_cnt == $past(cur_cnt)));
endmodule

// File: rtl/dcs_arb.sv
module dcs_arb #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  output logic [NCH-1:0] gnt,
  output logic [IW-1:0]  gidx,
  output logic           any
);
  always_comb begin
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        gidx   = IW'(i);
        any    = 1'b1;
      end
    end
  end

  // R2
  low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((elig & (gnt - NCH'(1))) == '0));
endmodule

// File: rtl/dcs_lat.sv
module dcs_lat #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend,
  input  logic          grant,
  input  logic          clr,
  output logic [LW-1:0] max_lat
);
  localparam logic [LW-1:0] FULL = '1;

  logic [LW-1:0] wait_q, n_wait, n_max;

  always_comb begin
    if (grant)                  n_wait = '0;
    else if (pend)              n_wait = (wait_q == FULL) ? FULL : wait_q + LW'(1);
    else                        n_wait = '0;
    if (clr)                    n_max = '0;
    else if (grant && wait_q > max_lat) n_max = wait_q;
    else                        n_max = max_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= '0;
      max_lat <= '0;
    end else begin
      wait_q  <= n_wait;
      max_lat <= n_max;
    end
  end

  // R10
  lat_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (max_lat >= $past(max_lat)));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dcs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int LW  = 4,
  parameter int DW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_ch,
  input  logic [3:0]     wr_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic [IW-1:0]  rd_ch,
  input  logic [3:0]     rd_sel,
  output logic [DW-1:0]  rd_data,
  output logic           bus_valid,
  output logic [AW-1:0]  bus_addr,
  output logic [IW-1:0]  bus_ch,
  input  logic           bus_done,
  input  logic           bus_err,
  output logic [NCH-1:0] irq
);
  logic [AW-1:0] c_addr [NCH];
  logic [AW-1:0] c_raddr[NCH];
  logic [CW-1:0] c_cnt  [NCH];
  logic [CW-1:0] c_rcnt [NCH];
  logic [2:0]    c_mode [NCH];
  logic [2:0]    c_mask [NCH];
  logic [LW-1:0] c_lat  [NCH];
  logic [3:0]    c_stat [NCH];
  logic [NCH-1:0] c_en, c_err, pend, elig, gnt;
  logic [IW-1:0]  gidx;
  logic           any;

  logic          busy_q, n_busy;
  logic [IW-1:0] gch_q, n_gch;
  logic [AW-1:0] gaddr_q, n_gaddr;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_w, remp, cmpl;
    assign sel_w = wr_en && (wr_ch == IW'(g));

    dcs_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(sel_w), .wr_sel(wr_sel), .wr_data(wr_data),
      .xfer_done(busy_q && bus_done && gch_q == IW'(g)),
      .xfer_err(bus_err),
      .cur_addr(c_addr[g]), .rld_addr(c_raddr[g]),
      .cur_cnt(c_cnt[g]), .rld_cnt(c_rcnt[g]),
      .mode(c_mode[g]), .ch_en(c_en[g]), .err_flag(c_err[g]),
      .imask(c_mask[g])
    );

    dcs_lat #(.LW(LW)) u_lat (
      .clk(clk), .rst_n(rst_n),
      .pend(pend[g]), .grant(gnt[g]),
      .clr(sel_w && wr_sel == SEL_LAT && wr_data[0]),
      .max_lat(c_lat[g])
    );

    assign remp      = (c_rcnt[g] == '0);
    assign cmpl      = remp && (c_cnt[g] == '0);
    assign c_stat[g] = {c_err[g], cmpl, remp, c_en[g]};
    assign pend[g]   = req[g] && c_en[g] && (c_cnt[g] != '0);
    assign elig[g]   = pend[g] && !busy_q;
    assign irq[g]    = |({c_err[g], cmpl, remp} & c_mask[g]);
  end

  dcs_arb #(.NCH(NCH), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig),
    .gnt(gnt), .gidx(gidx), .any(any)
  );

  always_comb begin
    n_busy  = busy_q;
    n_gch   = gch_q;
    n_gaddr = gaddr_q;
    if (busy_q) begin
      if (bus_done) n_busy = 1'b0;
    end else if (any) begin
      n_busy  = 1'b1;
      n_gch   = gidx;
      n_gaddr = c_addr[gidx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      gch_q   <= '0;
      gaddr_q <= '0;
    end else begin
      busy_q  <= n_busy;
      gch_q   <= n_gch;
      gaddr_q <= n_gaddr;
    end
  end

  assign bus_valid = busy_q;
  assign bus_ch    = gch_q;
  assign bus_addr  = gaddr_q;

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_ADDR:  rd_data = DW'(c_addr[rd_ch]);
      SEL_CNT:   rd_data = DW'(c_cnt[rd_ch]);
      SEL_ARLD:  rd_data = DW'(c_raddr[rd_ch]);
      SEL_CRLD:  rd_data = DW'(c_rcnt[rd_ch]);
      SEL_MODE:  rd_data = DW'(c_mode[rd_ch]);
      SEL_STAT:  rd_data = DW'(c_stat[rd_ch]);
      SEL_IESET: rd_data = DW'(c_mask[rd_ch]);
      SEL_LAT:   rd_data = DW'(c_lat[rd_ch]);
      default:   rd_data = '0;
    endcase
  end

  // R2
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_ch) && $stable(bus_addr)));

  // R2
  grant_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && |elig) |=> bus_valid);
endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;
  localparam int NCH = 4, AW = 16, CW = 8, LW = 4, DW = 16, IW = 2;
  localparam int LATFULL = (1 << LW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic [NCH-1:0] req;
  logic           wr_en;
  logic [IW-1:0]  wr_ch, rd_ch, bus_ch;
  logic [3:0]     wr_sel, rd_sel;
  logic [DW-1:0]  wr_data, rd_data;
  logic           bus_valid, bus_done, bus_err;
  logic [AW-1:0]  bus_addr;
  logic [NCH-1:0] irq;

  dma_chan_seq #(.NCH(NCH), .AW(AW), .CW(CW), .LW(LW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_ch(bus_ch),
    .bus_done(bus_done), .bus_err(bus_err), .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0, sweep = 0, wcnt = 0;
  bit err_next = 0;

  // reference model state
  int m_addr[NCH], m_cnt[NCH], m_ra[NCH], m_rc[NCH], m_mode[NCH];
  int m_en[NCH], m_err[NCH], m_mask[NCH], m_wait[NCH], m_max[NCH];
  int m_busy, m_ch, m_ga;

  function automatic int inc_of(int md);
    return ((md & 3) == 0) ? 1 : ((md & 3) == 1) ? 2 : 4;
  endfunction

  function automatic int stat_of(int c);
    int remp = (m_rc[c] == 0);
    int cmp  = remp && (m_cnt[c] == 0);
    return (m_err[c] << 3) | (cmp << 2) | (remp << 1) | m_en[c];
  endfunction

  function automatic int irq_of(int c);
    int s = stat_of(c);
    return ((((s >> 1) & 7) & m_mask[c]) != 0) ? 1 : 0;
  endfunction

  function automatic int mread(int c, int s);
    case (s)
      0: return m_addr[c];
      1: return m_cnt[c];
      2: return m_ra[c];
      3: return m_rc[c];
      5: return m_mode[c];
      6: return stat_of(c);
      7: return m_mask[c];
      9: return m_max[c];
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0, 1, 2, 3: return "R4";
      5: return "R3";
      6: return "R7";
      7, 8: return "R9";
      9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_addr[i] = 0; m_cnt[i] = 0; m_ra[i] = 0; m_rc[i] = 0; m_mode[i] = 0;
      m_en[i] = 0; m_err[i] = 0; m_mask[i] = 0; m_wait[i] = 0; m_max[i] = 0;
    end
    m_busy = 0; m_ch = 0; m_ga = 0;
  endtask

  task automatic model_step();
    int g = -1;
    int ga = 0;
    int pend[NCH];
    int fin = m_busy && bus_done;
    for (int i = 0; i < NCH; i++) pend[i] = req[i] && m_en[i] && (m_cnt[i] != 0);
    if (!m_busy) for (int i = NCH - 1; i >= 0; i--) if (pend[i]) g = i;
    if (g >= 0) ga = m_addr[g];
    for (int i = 0; i < NCH; i++) begin
      if (g == i) begin
        if (m_wait[i] > m_max[i]) m_max[i] = m_wait[i];
        m_wait[i] = 0;
      end else if (pend[i]) m_wait[i] = (m_wait[i] < LATFULL) ? m_wait[i] + 1 : LATFULL;
      else m_wait[i] = 0;
    end
    if (fin) begin
      int c = m_ch;
      if (bus_err) begin
        m_err[c] = 1; m_en[c] = 0;
      end else if (m_cnt[c] == 1 && m_rc[c] != 0) begin
        m_addr[c] = m_ra[c]; m_cnt[c] = m_rc[c];
        if ((m_mode[c] & 4) == 0) begin m_ra[c] = 0; m_rc[c] = 0; end
      end else begin
        m_addr[c] = (m_addr[c] + inc_of(m_mode[c])) & 16'hFFFF;
        m_cnt[c]  = (m_cnt[c] - 1) & 8'hFF;
      end
    end
    if (wr_en) begin
      int c = wr_ch;
      int d = wr_data;
      case (wr_sel)
        0: m_addr[c] = d;
        1: m_cnt[c] = d & 8'hFF;
        2: m_ra[c] = d;
        3: begin
          if (m_cnt[c] == 0) begin
            m_cnt[c] = d & 8'hFF; m_addr[c] = m_ra[c];
            if (m_mode[c] & 4) m_rc[c] = d & 8'hFF;
            else begin m_ra[c] = 0; m_rc[c] = 0; end
          end else m_rc[c] = d & 8'hFF;
        end
        4: begin
          if (d & 1) m_en[c] = 1;
          if (d & 2) m_en[c] = 0;
          if (d & 4) m_err[c] = 0;
        end
        5: m_mode[c] = d & 7;
        7: m_mask[c] = m_mask[c] | (d & 7);
        8: m_mask[c] = m_mask[c] & ~(d & 7);
        9: if (d & 1) m_max[c] = 0;
        default: ;
      endcase
    end
    if (m_busy) begin
      if (bus_done) m_busy = 0;
    end else if (g >= 0) begin
      m_busy = 1; m_ch = g; m_ga = ga;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic fail_line(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
  endtask

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) fail_line(tag, what, act, exp);
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      cmp("R2", "bus_valid", bus_valid, m_busy);
      if (m_busy) begin
        cmp("R2", "bus_ch", bus_ch, m_ch);
        cmp("R2", "bus_addr", bus_addr, m_ga);
      end
      for (int i = 0; i < NCH; i++) cmp("R9", "irq", irq[i], irq_of(i));
      cmp(tag_of(rd_sel), "rd_data", rd_data, mread(rd_ch, rd_sel));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      fail_line("R2", "watchdog cycles", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    wr_en = 1'b0;
    if (bus_valid) begin
      if (wcnt == 1) begin
        bus_done = 1'b1; bus_err = err_next; err_next = 0; wcnt = 0;
      end else begin
        bus_done = 1'b0; bus_err = 1'b0; wcnt++;
      end
    end else begin
      bus_done = 1'b0; bus_err = 1'b0; wcnt = 0;
    end
    rd_ch  = IW'((sweep / 10) % NCH);
    rd_sel = 4'((sweep % 10));
    sweep++;
  endtask

  task automatic wr(int ch, int sel, int d);
    tick();
    wr_en = 1'b1; wr_ch = IW'(ch); wr_sel = 4'(sel); wr_data = DW'(d);
  endtask

  task automatic chk(int ch, int sel, int exp, string tag);
    tick();
    rd_ch = IW'(ch); rd_sel = 4'(sel);
    #5;
    cmp(tag, "directed read", rd_data, exp);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; wr_en = 1'b0; wr_ch = '0; wr_sel = '0; wr_data = '0;
    rd_ch = '0; rd_sel = '0; bus_done = 1'b0; bus_err = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(0, 0, 0, "R1");
    chk(0, 1, 0, "R1");
    chk(2, 6, 6, "R1");
    cmp("R1", "bus_valid after reset", bus_valid, 0);
    cmp("R1", "irq after reset", irq, 0);

    // R6 immediate load, R3 halfword, R4 swap
    wr(1, 5, 1);
    wr(1, 2, 16'h100);
    wr(1, 3, 3);
    chk(1, 0, 16'h100, "R6");
    chk(1, 1, 3, "R6");
    chk(1, 2, 0, "R6");
    wr(1, 2, 16'h200);
    wr(1, 3, 2);
    chk(1, 3, 2, "R4");
    chk(1, 1, 3, "R4");
    wr(1, 4, 1);
    chk(1, 6, 1, "R11");
    tick(); req[1] = 1'b1;
    repeat (40) tick();
    req[1] = 1'b0;
    chk(1, 0, 16'h204, "R3");
    chk(1, 1, 0, "R4");
    chk(1, 6, 7, "R7");

    // R5 ring mode, word size
    wr(2, 5, 6);
    wr(2, 2, 16'h40);
    wr(2, 3, 2);
    chk(2, 0, 16'h40, "R6");
    wr(2, 4, 1);
    tick(); req[2] = 1'b1;
    repeat (30) tick();
    req[2] = 1'b0;
    wr(2, 4, 2);
    repeat (6) tick();
    chk(2, 3, 2, "R5");
    chk(2, 2, 16'h40, "R5");

    // R2 priority, R3 byte size, R10 saturation
    wr(0, 0, 16'h10);
    wr(0, 1, 20);
    wr(3, 1, 1);
    wr(0, 4, 1);
    wr(3, 4, 1);
    tick(); req[0] = 1'b1; req[3] = 1'b1;
    for (int k = 0; k < 10; k++) begin
      tick();
      #5;
      if (bus_valid) break;
    end
    cmp("R2", "first grant channel", bus_ch, 0);
    repeat (90) tick();
    req = '0;
    chk(0, 0, 16'h24, "R3");
    chk(3, 9, LATFULL, "R10");
    wr(3, 9, 1);
    chk(3, 9, 0, "R10");

    // R8 bus error
    wr(1, 3, 5);
    chk(1, 1, 5, "R6");
    wr(1, 4, 1);
    err_next = 1;
    tick(); req[1] = 1'b1;
    repeat (10) tick();
    req[1] = 1'b0;
    chk(1, 6, 16'hA, "R8");
    chk(1, 1, 5, "R8");
    wr(1, 4, 4);
    chk(1, 6, 2, "R8");

    // R9 interrupt mask
    wr(1, 7, 1);
    tick(); #5; cmp("R9", "irq[1] after mask set", irq[1], 1);
    wr(1, 7, 0);
    wr(1, 8, 0);
    chk(1, 7, 1, "R9");
    cmp("R9", "irq[1] after zero writes", irq[1], 1);
    wr(1, 8, 1);
    chk(1, 7, 0, "R9");
    cmp("R9", "irq[1] after mask clear", irq[1], 0);

    // R11 disable wins
    chk(0, 6, 7, "R7");
    wr(0, 4, 3);
    chk(0, 6, 6, "R11");

    repeat (5) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule